// File: doc/BRIEF.md
# PS/2 Host Command Transmitter

This block sends one command byte from a host to a PS/2 device over the two open-drain lines. When a command is accepted, it holds the clock line low for a fixed inhibit interval. It then pulls the data line low as the start bit and releases the clock. From that point the device generates the clock. The block puts each data bit on the line while the device holds the clock low, least significant bit first, and follows the data with an odd parity bit. It releases the data line for the stop bit and waits for the device to acknowledge by pulling data low and then pulsing the clock low. A single-cycle completion pulse ends the transfer. There is no timeout: a device that stops clocking leaves the block waiting.

Commands enter on a valid/ready pair. `cmd_ready` is high only while the block is idle, and a command transfers on a cycle where `cmd_valid` and `cmd_ready` are both high. A sender facing a low `cmd_ready` may keep `cmd_valid` and `cmd_data` asserted. Nothing is taken until the transfer in progress has finished, and `cmd_valid` during that time has no effect on the frame on the wire. A neighbouring PS/2 receiver should ignore the lines while `tx_busy` is high. It should restart its inactivity timer on `tx_done`.

Top module: `ps2_host_tx`

## Requirements
- R1: After reset, `cmd_ready` is 1 and `tx_busy`, `tx_done`, `ps2_clk_pull_o` and `ps2_dat_pull_o` are all 0.
- R2: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both 1. From the next cycle until `tx_done` is seen, `cmd_ready` is 0 and `tx_busy` is 1. A `cmd_valid` asserted during that time is ignored: it neither changes the byte being sent nor starts a second frame.
- R3: In the cycle after acceptance, the block begins pulling the clock low with data released. This lasts exactly CLK_FREQ_HZ/1e6 × INHIBIT_US cycles, which is 100 cycles at the defaults (100 µs at 1 MHz).
- R4: After the inhibit, data and clock are both pulled low for one cycle. The clock is then released while data stays pulled low (the start bit) until the device first drives the clock low.
- R5: Each data bit is placed on the line after the device's clock low is seen, in order from bit 0 to bit 7. Data is pulled low for a 0 bit and released for a 1 bit. Each bit is held until the clock is seen high again.
- R6: After the eighth data bit, one parity bit is sent in the same way. It is chosen so that the eight data bits plus the parity bit hold an odd number of ones.
- R7: At the first device clock low after the parity bit's high phase, the data line is released and stays released. The device therefore samples a stop bit of 1.
- R8: `tx_done` is 1 for exactly one cycle per frame. It occurs only after the device has pulled data low and then driven the clock low. `tx_busy` is 0 and `cmd_ready` is 1 in that same cycle.
- R9: Each line is only ever pulled low (pull output = 1) or released (pull output = 0). The clock pull is active only during the inhibit and start-bit phases. The data pull is active on the falling edge of the clock pull.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte offered |
| cmd_ready | output | 1 | Block idle; command can be taken |
| cmd_data | input | DATA_BITS | Command byte to send |
| ps2_clk_i | input | 1 | Sensed level of the PS/2 clock line (asynchronous) |
| ps2_dat_i | input | 1 | Sensed level of the PS/2 data line (asynchronous) |
| ps2_clk_pull_o | output | 1 | 1 pulls the clock line low, 0 releases it |
| ps2_dat_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| tx_busy | output | 1 | Transfer in progress; receiver should ignore the lines |
| tx_done | output | 1 | One-cycle pulse after the device's acknowledge |

## Verification
The embedded assertions watch several properties on every cycle. Acceptance must drop `cmd_ready` and raise `tx_busy`. The inhibit counter must step down one per cycle. The clock pull must never fall unless the data pull is active. The data pull must stay put while waiting for the clock to rise. `tx_done` must be a lone pulse that follows a sensed clock low. Other properties only show up end to end, through the bench's device model on the wired-AND lines. These are the exact inhibit length, the bit order and polarity the device samples on its rising edges, the parity value, the stop level, the placement of `tx_done` after the acknowledge, and the absence of any second frame when `cmd_valid` is held during a transfer.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

  typedef enum logic [3:0] {
    TX_IDLE,
    TX_INHIBIT,
    TX_START,
    TX_SETTLE,
    TX_BIT_LO,
    TX_BIT_HI,
    TX_STOP_LO,
    TX_STOP_HI,
    TX_ACK_DAT,
    TX_ACK_CLK
  } tx_state_e;

endpackage

// File: rtl/ps2tx_sync.sv
module ps2tx_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= RESET_VAL;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[s] <= RESET_VAL;
          else        chain_q[s] <= chain_q[s-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/ps2tx_inhibit_timer.sv
module ps2tx_inhibit_timer #(
  parameter int CYCLES = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);

  localparam int W = (CYCLES < 2) ? 1 : $clog2(CYCLES);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (load)                 cnt_q <= W'(CYCLES - 1);
    else if (run && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  assert_timer_steps_R3 : assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/ps2tx_frame_shift.sv
module ps2tx_frame_shift #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [DATA_BITS-1:0] data,
  input  logic                 advance,
  output logic                 cur_bit,
  output logic                 last
);

  localparam int FRAME_BITS = DATA_BITS + 1;
  localparam int CW         = $clog2(FRAME_BITS + 1);

  logic [FRAME_BITS-1:0] shift_q;
  logic [CW-1:0]         cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (load) begin
      shift_q <= {~(^data), data};
      cnt_q   <= '0;
    end else if (advance) begin
      shift_q <= shift_q >> 1;
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign cur_bit = shift_q[0];
  assign last    = (cnt_q == CW'(FRAME_BITS - 1));

  assert_parity_odd_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    load |=> ($countones(shift_q) % 2 == 1));

  assert_frame_bound_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q <= CW'(FRAME_BITS)));

endmodule

// File: rtl/ps2_host_tx.sv
module ps2_host_tx
  import ps2tx_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 1_000_000,
  parameter int INHIBIT_US  = 100,
  parameter int DATA_BITS   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic [DATA_BITS-1:0] cmd_data,
  input  logic                 ps2_clk_i,
  input  logic                 ps2_dat_i,
  output logic                 ps2_clk_pull_o,
  output logic                 ps2_dat_pull_o,
  output logic                 tx_busy,
  output logic                 tx_done
);

  localparam int RAW_INHIBIT    = (CLK_FREQ_HZ / 1_000_000) * INHIBIT_US;
  localparam int INHIBIT_CYCLES = (RAW_INHIBIT < 1) ? 1 : RAW_INHIBIT;

  tx_state_e state_q, state_d;
  logic clk_s, dat_s;
  logic tmr_load, tmr_expired;
  logic frm_load, frm_adv, frm_bit, frm_last;
  logic dat_pull_q, done_q;

  ps2tx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_clk_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ps2_clk_i), .sync_out(clk_s));

  ps2tx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_dat_sync (
    .clk(clk), .rst_n(rst_n), .async_in(ps2_dat_i), .sync_out(dat_s));

  ps2tx_inhibit_timer #(.CYCLES(INHIBIT_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load),
    .run(state_q == TX_INHIBIT), .expired(tmr_expired));

  ps2tx_frame_shift #(.DATA_BITS(DATA_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .load(frm_load), .data(cmd_data),
    .advance(frm_adv), .cur_bit(frm_bit), .last(frm_last));

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    frm_load = 1'b0;
    frm_adv  = 1'b0;
    unique case (state_q)
      TX_IDLE: if (cmd_valid) begin
        state_d  = TX_INHIBIT;
        tmr_load = 1'b1;
        frm_load = 1'b1;
      end
      TX_INHIBIT: if (tmr_expired) state_d = TX_START;
      TX_START:   state_d = TX_SETTLE;
      TX_SETTLE:  if (clk_s)  state_d = TX_BIT_LO;
      TX_BIT_LO:  if (!clk_s) state_d = TX_BIT_HI;
      TX_BIT_HI:  if (clk_s) begin
        frm_adv = 1'b1;
        state_d = frm_last ? TX_STOP_LO : TX_BIT_LO;
      end
      TX_STOP_LO: if (!clk_s) state_d = TX_STOP_HI;
      TX_STOP_HI: if (clk_s)  state_d = TX_ACK_DAT;
      TX_ACK_DAT: if (!dat_s) state_d = TX_ACK_CLK;
      TX_ACK_CLK: if (!clk_s) state_d = TX_IDLE;
      default:    state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= TX_IDLE;
      dat_pull_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == TX_ACK_CLK) && !clk_s;
      if (state_q == TX_INHIBIT && tmr_expired)   dat_pull_q <= 1'b1;
      else if (state_q == TX_BIT_LO && !clk_s)    dat_pull_q <= ~frm_bit;
      else if (state_q == TX_STOP_LO && !clk_s)   dat_pull_q <= 1'b0;
      else if (state_q == TX_IDLE)                dat_pull_q <= 1'b0;
    end
  end

  assign cmd_ready      = (state_q == TX_IDLE);
  assign tx_busy        = (state_q != TX_IDLE);
  assign tx_done        = done_q;
  assign ps2_clk_pull_o = (state_q == TX_INHIBIT) || (state_q == TX_START);
  assign ps2_dat_pull_o = dat_pull_q;

  assert_accept_busy_R2 : assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> (!cmd_ready && tx_busy));

  assert_clk_release_start_R4 : assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_pull_o) |-> ps2_dat_pull_o);

  assert_bit_hold_R5 : assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TX_BIT_HI && $past(state_q) == TX_BIT_HI) |-> $stable(ps2_dat_pull_o));

  assert_done_single_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  assert_done_after_clk_low_R8 : assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> !$past(clk_s));

  assert_clk_pull_busy_R9 : assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_pull_o |-> (tx_busy && !tx_done));

endmodule

// File: tb/tb_ps2_host_tx.sv
module tb_ps2_host_tx;

  localparam int CLK_PERIOD = 10;
  localparam int INHIBIT    = 100;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic cmd_ready, clk_pull, dat_pull, tx_busy, tx_done;
  logic dev_clk_low = 1'b0;
  logic dev_dat_low = 1'b0;
  logic clk_line, dat_line;

  int compared = 0;
  int mismatched = 0;
  int done_cnt = 0;

  assign clk_line = !(clk_pull || dev_clk_low);
  assign dat_line = !(dat_pull || dev_dat_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_tx dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_data(cmd_data), .ps2_clk_i(clk_line), .ps2_dat_i(dat_line),
    .ps2_clk_pull_o(clk_pull), .ps2_dat_pull_o(dat_pull),
    .tx_busy(tx_busy), .tx_done(tx_done));

  always @(negedge clk) if (tx_done) done_cnt++;

  function automatic logic odd_parity(input logic [7:0] b);
    return ~(^b);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic device_frame(input logic [7:0] sent, input int half);
    int inh = 0;
    logic [7:0] got = '0;
    logic par, stp;
    while (!clk_pull) @(negedge clk);
    check(!cmd_ready && tx_busy, "R2 busy during frame", {cmd_ready, tx_busy}, 2'b01);
    while (clk_pull && !dat_pull) begin inh++; @(negedge clk); end
    check(inh == INHIBIT, "R3 inhibit length", inh, INHIBIT);
    check(clk_pull && dat_pull, "R4 both pulled", {clk_pull, dat_pull}, 2'b11);
    while (clk_pull) @(negedge clk);
    repeat (10) @(negedge clk);
    check(dat_pull && !clk_pull, "R4 start bit held", {clk_pull, dat_pull}, 2'b01);
    for (int k = 0; k < 10; k++) begin
      dev_clk_low = 1'b1;
      repeat (half) @(negedge clk);
      if (k < 8) got[k] = dat_line;
      else if (k == 8) par = dat_line;
      else stp = dat_line;
      dev_clk_low = 1'b0;
      repeat (half) @(negedge clk);
    end
    check(got == sent, "R5 data bits", got, sent);
    check(par == odd_parity(sent), "R6 parity", par, odd_parity(sent));
    check(stp == 1'b1 && !dat_pull, "R7 stop released", {stp, dat_pull}, 2'b10);
    check(done_cnt == 0, "R8 no done before ack", done_cnt, 0);
    dev_dat_low = 1'b1;
    repeat (4) @(negedge clk);
    check(done_cnt == 0, "R8 no done on data ack alone", done_cnt, 0);
    dev_clk_low = 1'b1;
    repeat (half) @(negedge clk);
    dev_clk_low = 1'b0;
    dev_dat_low = 1'b0;
    repeat (3) @(negedge clk);
    check(done_cnt == 1, "R8 single done", done_cnt, 1);
    check(!tx_busy && cmd_ready && !clk_pull && !dat_pull, "R9 lines released idle",
          {tx_busy, cmd_ready, clk_pull, dat_pull}, 4'b0100);
  endtask

  task automatic run_frame(input logic [7:0] b, input int half);
    done_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    device_frame(b, half);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] directed [5] = '{8'h00, 8'hFF, 8'h01, 8'h80, 8'hED};
    void'($urandom(32'h5EED_0A17));
    repeat (3) @(negedge clk);
    check(cmd_ready && !tx_busy && !tx_done && !clk_pull && !dat_pull, "R1 reset state",
          {cmd_ready, tx_busy, tx_done, clk_pull, dat_pull}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cmd_ready && !clk_pull && !dat_pull, "R1 after release",
          {cmd_ready, clk_pull, dat_pull}, 3'b100);

    foreach (directed[i]) run_frame(directed[i], 8 + 4 * i);

    // R2: hold cmd_valid with another byte during a transfer
    begin
      logic [7:0] b = 8'h5A;
      int ready_seen = 0;
      done_cnt = 0;
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_data  = b;
      @(negedge clk);
      cmd_data = ~b;
      fork
        device_frame(b, 12);
        begin
          repeat (60) begin
            if (cmd_ready) ready_seen++;
            @(negedge clk);
          end
          cmd_valid = 1'b0;
        end
      join
      check(ready_seen == 0, "R2 ready low while busy", ready_seen, 0);
      repeat (20) @(negedge clk);
      check(!clk_pull && !tx_busy, "R2 no second frame", {clk_pull, tx_busy}, 2'b00);
    end

    for (int n = 0; n < 12; n++) begin
      logic [7:0] b = 8'($urandom);
      int half = 8 + int'($urandom % 23);
      repeat (int'($urandom % 5)) @(negedge clk);
      run_frame(b, half);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule